// File: doc/BRIEF.md
# Timed Single-Bit Holding Buffer

This block holds one bit for a bounded stretch of time. While it is empty it accepts a bit from its input port and starts a dwell counter at zero. The counter advances only on cycles where the `tick` input is high, so one tick is one unit of time. The stored bit may leave once a minimum number of ticks has passed, and it leaves when the release enable is high. When the counter reaches the maximum dwell, the bit leaves whatever the enable says. The buffer then becomes empty again.

The block suits a design that must forward a sample no sooner than a settling delay and no later than a deadline. One example is a timed relay between two agents that coordinate only through elapsed time. The buffer holds one value only. An input that arrives while the buffer is full is not stored, and a one-cycle drop flag reports it. The output is a one-cycle valid pulse and cannot be stalled.

Top module: `timed_hold_buf`

## Requirements
- R1: While `rst` is high at a clock edge, the block goes to empty with the dwell count at zero. After that edge `full`, `out_vld` and `drop` are all 0.
- R2: When `full` is 0 and `in_vld` is 1 at a clock edge, `in_bit` is stored and the dwell count is set to zero. From that edge on, `full` reads 1.
- R3: The stored bit is not released until the dwell count has reached MIN_DWELL (default 2) ticks, even if `rel_en` is held high.
- R4: The stored bit is released at a clock edge where the dwell count is at least MIN_DWELL and below MAX_DWELL and `rel_en` is 1. After that edge, `out_vld` is 1 and `out_bit` equals the stored bit.
- R5: When the dwell count reaches MAX_DWELL (default 3) ticks, the stored bit is released at the next clock edge even if `rel_en` is 0. The buffer therefore never stays full past MAX_DWELL ticks.
- R6: `out_vld` is high for exactly one cycle. During that cycle `full` is 0.
- R7: An `in_vld` that arrives while `full` is 1 is not stored, and the held bit is what later leaves on `out_bit`. `drop` is 1 for exactly the one cycle after that edge.
- R8: The dwell count advances only on edges where `tick` is 1. With no ticks the buffer stays full for any number of cycles, whatever `rel_en` does.
- R9: Ticks while the buffer is empty do not carry over. After a capture, the count starts from zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One time unit elapses on this edge |
| in_vld | input | 1 | Input bit offered |
| in_bit | input | 1 | Input data bit |
| rel_en | input | 1 | Permits release inside the dwell window |
| out_vld | output | 1 | One-cycle release pulse |
| out_bit | output | 1 | Released bit, meaningful with out_vld |
| full | output | 1 | 1 while a bit is held |
| drop | output | 1 | One-cycle pulse: input refused while full |

## Verification
Every output is registered. A capture shows on `full` one edge after `in_vld`, and a refusal shows on `drop` one edge after `in_vld` as well. A release decision is made at the edge where the count already holds the required ticks, so `out_vld` rises one edge after the count reaches MIN_DWELL with `rel_en` high. In the same way it rises one edge after the count reaches MAX_DWELL with `rel_en` low. The bench drives inputs on the falling edge and reads results on the next falling edge, which puts every sample exactly one register stage after its cause. To pin the lower bound, it reads the outputs again after each added tick.

// File: rtl/hb_pkg.sv
`timescale 1ns/1ps
package hb_pkg;
    typedef enum logic {
        HB_EMPTY = 1'b0,
        HB_HELD  = 1'b1
    } hb_mode_e;
endpackage

// File: rtl/hb_dwell_timer.sv
`timescale 1ns/1ps
module hb_dwell_timer #(
    parameter int MIN_DWELL = 2,
    parameter int MAX_DWELL = 3,
    parameter int AGE_W     = 2
) (
    input  logic             held,
    input  logic             clear,
    input  logic             tick,
    input  logic [AGE_W-1:0] age_q,
    output logic [AGE_W-1:0] age_d,
    output logic             min_met,
    output logic             max_hit
);
    localparam logic [AGE_W-1:0] MIN_A = AGE_W'(MIN_DWELL);
    localparam logic [AGE_W-1:0] MAX_A = AGE_W'(MAX_DWELL);

    always_comb begin
        if (clear)
            age_d = '0;
        else if (held && tick && (age_q < MAX_A))
            age_d = age_q + 1'b1;
        else
            age_d = age_q;
        min_met = (age_q >= MIN_A);
        max_hit = (age_q >= MAX_A);
    end
endmodule

// File: rtl/hb_release_arb.sv
`timescale 1ns/1ps
module hb_release_arb #(
    parameter int MIN_DWELL = 2,
    parameter int MAX_DWELL = 3
) (
    input  logic held,
    input  logic min_met,
    input  logic max_hit,
    input  logic rel_en,
    output logic release_now
);
    generate
        if (MIN_DWELL >= MAX_DWELL) begin : g_deadline_only
            logic unused_ok;
            assign unused_ok   = min_met ^ rel_en;
            assign release_now = held && max_hit;
        end else begin : g_windowed
            assign release_now = held && (max_hit || (min_met && rel_en));
        end
    endgenerate
endmodule

// File: rtl/timed_hold_buf.sv
`timescale 1ns/1ps
module timed_hold_buf #(
    parameter int MIN_DWELL = 2,
    parameter int MAX_DWELL = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic in_vld,
    input  logic in_bit,
    input  logic rel_en,
    output logic out_vld,
    output logic out_bit,
    output logic full,
    output logic drop
);
    import hb_pkg::*;

    localparam int AGE_W = (MAX_DWELL < 1) ? 1 : $clog2(MAX_DWELL + 1);

    typedef struct packed {
        hb_mode_e         mode;
        logic             data;
        logic [AGE_W-1:0] age;
        logic             ovld;
        logic             obit;
        logic             drop;
    } hb_state_t;

    hb_state_t st_q, st_d;

    logic             capture, release_now, min_met, max_hit, is_held;
    logic [AGE_W-1:0] age_d;

    assign is_held = (st_q.mode == HB_HELD);
    assign capture = !is_held && in_vld;

    hb_dwell_timer #(
        .MIN_DWELL(MIN_DWELL), .MAX_DWELL(MAX_DWELL), .AGE_W(AGE_W)
    ) u_timer (
        .held(is_held), .clear(capture || release_now), .tick(tick),
        .age_q(st_q.age), .age_d(age_d), .min_met(min_met), .max_hit(max_hit)
    );

    hb_release_arb #(
        .MIN_DWELL(MIN_DWELL), .MAX_DWELL(MAX_DWELL)
    ) u_arb (
        .held(is_held), .min_met(min_met), .max_hit(max_hit),
        .rel_en(rel_en), .release_now(release_now)
    );

    always_comb begin
        st_d      = st_q;
        st_d.age  = age_d;
        st_d.ovld = 1'b0;
        st_d.drop = is_held && in_vld;
        if (capture) begin
            st_d.mode = HB_HELD;
            st_d.data = in_bit;
        end else if (release_now) begin
            st_d.mode = HB_EMPTY;
            st_d.ovld = 1'b1;
            st_d.obit = st_q.data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            st_q <= '{mode: HB_EMPTY, data: 1'b0, age: '0,
                      ovld: 1'b0, obit: 1'b0, drop: 1'b0};
        else
            st_q <= st_d;
    end

    assign out_vld = st_q.ovld;
    assign out_bit = st_q.obit;
    assign full    = is_held;
    assign drop    = st_q.drop;
endmodule

// File: rtl/hb_checker.sv
`timescale 1ns/1ps
module hb_checker #(
    parameter int MIN_DWELL = 2,
    parameter int MAX_DWELL = 3
) (
    input logic clk,
    input logic rst,
    input logic tick,
    input logic in_vld,
    input logic out_vld,
    input logic full,
    input logic drop
);
    localparam int CW = $clog2(MAX_DWELL + 2) + 1;
    logic [CW-1:0] ticks_q;

    always_ff @(posedge clk) begin
        if (rst || !full)
            ticks_q <= '0;
        else if (tick && (int'(ticks_q) <= MAX_DWELL))
            ticks_q <= ticks_q + 1'b1;
    end

    // R2
    capture_when_empty_chk: assert property (@(posedge clk) disable iff (rst)
        (!full && in_vld) |=> full);
    // R3
    min_dwell_chk: assert property (@(posedge clk) disable iff (rst)
        out_vld |-> (int'($past(ticks_q)) >= MIN_DWELL));
    // R5
    max_dwell_chk: assert property (@(posedge clk) disable iff (rst)
        full |-> (int'(ticks_q) <= MAX_DWELL));
    // R6
    single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        out_vld |=> !out_vld);
    // R6
    empty_on_release_chk: assert property (@(posedge clk) disable iff (rst)
        out_vld |-> (!full && $past(full)));
    // R7
    drop_cause_chk: assert property (@(posedge clk) disable iff (rst)
        drop |-> $past(full && in_vld));
endmodule

bind timed_hold_buf hb_checker #(
    .MIN_DWELL(MIN_DWELL), .MAX_DWELL(MAX_DWELL)
) u_chk (
    .clk(clk), .rst(rst), .tick(tick), .in_vld(in_vld),
    .out_vld(out_vld), .full(full), .drop(drop)
);

// File: tb/sim_timed_hold_buf.sv
`timescale 1ns/1ps
module sim_timed_hold_buf;
    logic clk = 1'b0, rst = 1'b1, tick = 1'b0, in_vld = 1'b0, in_bit = 1'b0, rel_en = 1'b0;
    logic out_vld, out_bit, full, drop;
    int n_run = 0, n_fail = 0;

    always #5 clk = ~clk;

    timed_hold_buf u0 (
        .clk(clk), .rst(rst), .tick(tick), .in_vld(in_vld), .in_bit(in_bit),
        .rel_en(rel_en), .out_vld(out_vld), .out_bit(out_bit), .full(full), .drop(drop)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b", req, act, exp);
        end
    endtask

    task automatic cyc(input int n = 1);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic load(input logic b);
        in_vld = 1'b1; in_bit = b;
        cyc();
        in_vld = 1'b0;
        chk("R2 full after capture", full, 1'b1);
    endtask

    task automatic t_reset();
        rst = 1'b1; cyc(3);
        chk("R1 full", full, 1'b0);
        chk("R1 out_vld", out_vld, 1'b0);
        chk("R1 drop", drop, 1'b0);
        rst = 1'b0;
    endtask

    task automatic t_enable_release();
        load(1'b1);
        tick = 1'b1; cyc(2); tick = 1'b0;
        chk("R4 held before enable", full, 1'b1);
        chk("R4 no pulse before enable", out_vld, 1'b0);
        rel_en = 1'b1; cyc(); rel_en = 1'b0;
        chk("R4 out_vld", out_vld, 1'b1);
        chk("R4 out_bit", out_bit, 1'b1);
        chk("R6 empty during pulse", full, 1'b0);
        cyc();
        chk("R6 pulse one cycle", out_vld, 1'b0);
    endtask

    task automatic t_min_bound();
        rel_en = 1'b1;
        load(1'b0);
        tick = 1'b1; cyc();
        chk("R3 no release at 1 tick", out_vld, 1'b0);
        cyc(); tick = 1'b0;
        chk("R3 no release on edge reaching min", out_vld, 1'b0);
        cyc();
        chk("R4 release at min", out_vld, 1'b1);
        chk("R4 bit zero", out_bit, 1'b0);
        rel_en = 1'b0; cyc();
    endtask

    task automatic t_forced();
        load(1'b1);
        tick = 1'b1; cyc(3); tick = 1'b0;
        chk("R5 still held at max count", full, 1'b1);
        chk("R5 no pulse yet", out_vld, 1'b0);
        cyc();
        chk("R5 forced out_vld", out_vld, 1'b1);
        chk("R5 forced out_bit", out_bit, 1'b1);
        chk("R5 empty after forced", full, 1'b0);
        cyc();
    endtask

    task automatic t_no_tick();
        load(1'b0);
        rel_en = 1'b1; cyc(20);
        chk("R8 held without ticks", full, 1'b1);
        chk("R8 no pulse without ticks", out_vld, 1'b0);
        rel_en = 1'b0;
        tick = 1'b1; cyc(3); tick = 1'b0; cyc(2);
        chk("R8 drained", full, 1'b0);
    endtask

    task automatic t_drop();
        load(1'b1);
        in_vld = 1'b1; in_bit = 1'b0; cyc(); in_vld = 1'b0;
        chk("R7 drop pulse", drop, 1'b1);
        chk("R7 still full", full, 1'b1);
        cyc();
        chk("R7 drop one cycle", drop, 1'b0);
        tick = 1'b1; cyc(3); tick = 1'b0; cyc();
        chk("R7 out_vld", out_vld, 1'b1);
        chk("R7 held bit kept", out_bit, 1'b1);
        cyc();
    endtask

    task automatic t_empty_ticks();
        tick = 1'b1; cyc(10); tick = 1'b0;
        chk("R9 empty after ticks", full, 1'b0);
        rel_en = 1'b1;
        load(1'b1);
        tick = 1'b1; cyc(); tick = 1'b0; cyc();
        chk("R9 count restarted", out_vld, 1'b0);
        chk("R9 still held", full, 1'b1);
        tick = 1'b1; cyc(); tick = 1'b0; cyc();
        chk("R9 release after two ticks", out_vld, 1'b1);
        rel_en = 1'b0; cyc();
    endtask

    initial begin
        #2000000;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        cyc();
        t_reset();
        t_enable_release();
        t_min_bound();
        t_forced();
        t_no_tick();
        t_drop();
        t_empty_ticks();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule